// File: doc/BRIEF.md
# Synthesizer PLL and Output Divider Parameter Encoder

This block turns the settings of a clock synthesizer channel into the register writes that program it. It takes a fractional feedback multiplier (integer part, 20-bit numerator and 20-bit denominator), the integer ratio of one output divider, and a 3-bit output power-of-two divide code. From these it derives the three packed parameters that the synthesizer expects for each stage, called P1, P2 and P3 here. For the fractional feedback stage the quotient t = floor(128·num/denom) is found with a sequential divider. The block then sends sixteen single-byte writes to a downstream write sequencer: eight for the feedback stage, then eight for the output divider.

A controller pulses `start` with the settings on the inputs and then waits for `done`. The denominator is normally held at 1048575, but any non-zero value is accepted. Each write is offered as an address/data pair with `wr_valid`, and the write sequencer takes it by raising `wr_ready`. Selecting the multiplier and divider for a target frequency is left to the controller, and so is the serial bus timing.

Top module: `synth_param_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `wr_valid` and `done` are all 0.
- R2: `start` is taken only on a rising clock edge where `busy` is 0. All settings are captured on that edge. Later changes to the settings have no effect on the burst, and a `start` that arrives while `busy` is 1 is ignored.
- R3: Feedback stage, with t = floor(128·num/denom): P1 = (128·mult + t − 512) mod 2^18, P2 = 128·num − denom·t (the remainder, 20 bits), and P3 = denom.
- R4: Output divider: P1 = (128·div − 512) mod 2^18, P2 = 0 and P3 = 1. The 3-bit divide code is placed in bits 6:4 of the byte at offset +2.
- R5: Byte at each offset from a stage's base: +0 = P3[15:8], +1 = P3[7:0], +2 = P1[17:16] in bits 1:0, +3 = P1[15:8], +4 = P1[7:0], +5 = P3[19:16] in bits 7:4 with P2[19:16] in bits 3:0, +6 = P2[15:8], +7 = P2[7:0].
- R6: The feedback-stage writes go to addresses 26..33 in ascending order. The output-divider writes to addresses 42..49 in ascending order follow them.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the request stays up with `wr_addr` and `wr_data` unchanged. Each cycle with both signals high completes exactly one write.
- R8: The first write request appears 27 clock edges after the edge that takes `start`. This is the count of divider steps, NUM_W + 7.
- R9: `busy` is 1 from the edge that takes `start` until the sixteenth write is accepted. `done` is a one-cycle pulse in the cycle after that acceptance, and `busy` is 0 during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to encode and send the current settings |
| mult | input | 8 | Integer part of the feedback multiplier |
| num | input | 20 | Fractional numerator |
| denom | input | 20 | Fractional denominator (normally 1048575) |
| ms_div | input | 12 | Integer ratio of the output divider |
| rdiv | input | 3 | Output power-of-two divide code |
| wr_ready | input | 1 | Write sequencer accepts the offered write |
| busy | output | 1 | A burst is being computed or sent |
| wr_valid | output | 1 | A write request is offered |
| wr_addr | output | 8 | Register address of the offered write |
| wr_data | output | 8 | Register data of the offered write |
| done | output | 1 | One-cycle pulse after the last write is accepted |

## Verification
The settings tried are:
- an exact integer multiplier (numerator 0), which separates P1 from the quotient path;
- mid-range and near-full numerators against the fixed denominator, which stress the carries in the 128·mult + t sum and the top nibble of the remainder;
- a small denominator and a numerator larger than the denominator, which drive the quotient past 127 and check the P1 wraparound.

Non-zero divide codes show whether the code lands in the right bits of the +2 byte without disturbing P1[17:16]. The acceptance patterns for `wr_ready` are always-ready, alternating and irregular, and they separate correct holding of a request from skipped or repeated writes. In every run the settings are changed and a stray `start` is pulsed during the burst, which exposes any late sampling of the inputs.

// File: rtl/synth_enc_pkg.sv
package synth_enc_pkg;
  // Field widths fixed by the synthesizer's register format.
  localparam int P1_W   = 18;
  localparam int P2_W   = 20;
  localparam int P3_W   = 20;
  localparam int RDIV_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_SEND} enc_state_t;

  typedef struct packed {
    logic [P3_W-1:0] p3;
    logic [P2_W-1:0] p2;
    logic [P1_W-1:0] p1;
  } synth_par_t;

  // Fractional feedback stage: the quotient t and remainder come from the divider.
  function automatic synth_par_t frac_par(input logic [P1_W-1:0] m, input logic [P1_W-1:0] t,
                                          input logic [P2_W-1:0] rem, input logic [P3_W-1:0] den);
    synth_par_t r;
    r.p1 = (m << 7) + t - P1_W'(512);
    r.p2 = rem;
    r.p3 = den;
    return r;
  endfunction

  // Integer output divider.
  function automatic synth_par_t int_par(input logic [P1_W-1:0] d);
    synth_par_t r;
    r.p1 = (d << 7) - P1_W'(512);
    r.p2 = '0;
    r.p3 = P3_W'(1);
    return r;
  endfunction

  // Byte at offset idx of an eight-register burst.
  function automatic logic [7:0] reg_byte(input synth_par_t p, input logic [2:0] idx,
                                          input logic [7:0] extra2);
    logic [7:0] b;
    case (idx)
      3'd0:    b = p.p3[15:8];
      3'd1:    b = p.p3[7:0];
      3'd2:    b = {6'b0, p.p1[17:16]} | extra2;
      3'd3:    b = p.p1[15:8];
      3'd4:    b = p.p1[7:0];
      3'd5:    b = {p.p3[19:16], p.p2[19:16]};
      3'd6:    b = p.p2[15:8];
      default: b = p.p2[7:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/frac_restoring_div.sv
module frac_restoring_div #(
  parameter int DEND_W = 27,
  parameter int DSOR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEND_W-1:0] dividend,
  input  logic [DSOR_W-1:0] divisor,
  output logic              run,
  output logic              last_step,
  output logic [DEND_W-1:0] quot,
  output logic [DSOR_W-1:0] rem,
  output logic [DSOR_W-1:0] dsor
);
  localparam int CNT_W = $clog2(DEND_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [DSOR_W:0]  trial;
  logic [DSOR_W:0]  diff;
  logic             fits;

  always_comb begin
    trial     = {rem, quot[DEND_W-1]};
    diff      = trial - {1'b0, dsor};
    fits      = (trial >= {1'b0, dsor});
    last_step = run && (cnt == CNT_W'(DEND_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      quot <= '0;
      rem  <= '0;
      dsor <= '0;
    end else if (load) begin
      run  <= 1'b1;
      cnt  <= '0;
      quot <= dividend;
      rem  <= '0;
      dsor <= divisor;
    end else if (run) begin
      quot <= {quot[DEND_W-2:0], fits};
      rem  <= fits ? diff[DSOR_W-1:0] : trial[DSOR_W-1:0];
      cnt  <= cnt + 1'b1;
      if (last_step) run <= 1'b0;
    end
  end

  // R3: the partial remainder stays below a non-zero divisor through every step
  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dsor != '0) |=> (rem < dsor));
endmodule

// File: rtl/burst_packer.sv
module burst_packer
  import synth_enc_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int DIV_W    = 12,
  parameter int QUOT_W   = 27,
  parameter int NUM_W    = 20,
  parameter int IDX_W    = 4,
  parameter int PLL_BASE = 26,
  parameter int MS_BASE  = 42
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [DIV_W-1:0]  ms_div,
  input  logic [RDIV_W-1:0] rdiv,
  input  logic [QUOT_W-1:0] quot,
  input  logic [NUM_W-1:0]  rem,
  input  logic [NUM_W-1:0]  den,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        addr,
  output logic [7:0]        data
);
  synth_par_t pll_p;
  synth_par_t ms_p;
  logic       sel_ms;
  logic [2:0] byte_i;
  logic [7:0] extra2;

  always_comb begin
    pll_p  = frac_par(P1_W'(mult), P1_W'(quot), P2_W'(rem), P3_W'(den));
    ms_p   = int_par(P1_W'(ms_div));
    sel_ms = idx[IDX_W-1];
    byte_i = idx[2:0];
    extra2 = sel_ms ? {1'b0, rdiv, 4'b0000} : 8'h00;
    data   = reg_byte(sel_ms ? ms_p : pll_p, byte_i, extra2);
    addr   = (sel_ms ? 8'(MS_BASE) : 8'(PLL_BASE)) + {5'b0, byte_i};
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import synth_enc_pkg::*;
#(
  parameter int BURST_LEN = 16,
  parameter int IDX_W     = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_ready,
  input  logic             div_last,
  output logic             accept,
  output logic             busy,
  output logic             wr_valid,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  enc_state_t state;
  logic       last_idx;

  always_comb begin
    accept   = start && (state == S_IDLE);
    busy     = (state != S_IDLE);
    wr_valid = (state == S_SEND);
    last_idx = (idx == IDX_W'(BURST_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state <= S_DIV;
          idx   <= '0;
        end
        S_DIV: if (div_last) state <= S_SEND;
        S_SEND: if (wr_ready) begin
          if (last_idx) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle and the block is idle during it
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/synth_param_encoder.sv
module synth_param_encoder
  import synth_enc_pkg::*;
#(
  parameter int MULT_W   = 8,
  parameter int NUM_W    = 20,
  parameter int DIV_W    = 12,
  parameter int FRAC_SH  = 7,
  parameter int PLL_BASE = 26,
  parameter int MS_BASE  = 42,
  parameter int REGS     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MULT_W-1:0] mult,
  input  logic [NUM_W-1:0]  num,
  input  logic [NUM_W-1:0]  denom,
  input  logic [DIV_W-1:0]  ms_div,
  input  logic [RDIV_W-1:0] rdiv,
  input  logic              wr_ready,
  output logic              busy,
  output logic              wr_valid,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);
  localparam int QUOT_W    = NUM_W + FRAC_SH;
  localparam int BURST_LEN = 2 * REGS;
  localparam int IDX_W     = $clog2(BURST_LEN);

  logic              accept;
  logic              div_run;
  logic              div_last;
  logic [QUOT_W-1:0] quot;
  logic [NUM_W-1:0]  rem;
  logic [NUM_W-1:0]  den_q;
  logic [IDX_W-1:0]  idx;
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;
  logic [RDIV_W-1:0] rdiv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q <= '0;
      div_q  <= '0;
      rdiv_q <= '0;
    end else if (accept) begin
      mult_q <= mult;
      div_q  <= ms_div;
      rdiv_q <= rdiv;
    end
  end

  frac_restoring_div #(.DEND_W(QUOT_W), .DSOR_W(NUM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .dividend({num, {FRAC_SH{1'b0}}}), .divisor(denom),
    .run(div_run), .last_step(div_last), .quot(quot), .rem(rem), .dsor(den_q)
  );

  burst_seq #(.BURST_LEN(BURST_LEN), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_ready(wr_ready), .div_last(div_last),
    .accept(accept), .busy(busy), .wr_valid(wr_valid), .done(done), .idx(idx)
  );

  burst_packer #(.MULT_W(MULT_W), .DIV_W(DIV_W), .QUOT_W(QUOT_W), .NUM_W(NUM_W),
                 .IDX_W(IDX_W), .PLL_BASE(PLL_BASE), .MS_BASE(MS_BASE)) u_pack (
    .mult(mult_q), .ms_div(div_q), .rdiv(rdiv_q), .quot(quot), .rem(rem), .den(den_q),
    .idx(idx), .addr(wr_addr), .data(wr_data)
  );

  // R7: a stalled request keeps its address and data
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R6: every burst opens at the feedback-stage base
  a_r6_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_addr == 8'(PLL_BASE)));
  // R8: no write is offered while the divider is still stepping
  a_r8_div_finished: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !div_run);
  // R2: captured settings do not move during a burst
  a_r2_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mult_q) && $stable(div_q) && $stable(rdiv_q) && $stable(den_q)));
  // R9: done follows the acceptance of the last divider register
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready && wr_addr == 8'(MS_BASE + REGS - 1)));
endmodule

// File: tb/synth_param_encoder_bench.sv
module synth_param_encoder_bench;
  localparam int LAT = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mult = '0;
  logic [19:0] num = '0;
  logic [19:0] denom = '0;
  logic [11:0] ms_div = '0;
  logic [2:0]  rdiv = '0;
  logic        wr_ready = 1'b0;
  logic        busy, wr_valid, done;
  logic [7:0]  wr_addr, wr_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int rdy_mode = 0;

  // reference model state
  int m_state = 0;
  int m_cnt = 0;
  bit m_done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  synth_param_encoder u_synth_param_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .mult(mult), .num(num), .denom(denom),
    .ms_div(ms_div), .rdiv(rdiv), .wr_ready(wr_ready), .busy(busy), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  task automatic check(input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic void push_stage(int base, longint p1, longint p2, longint p3, int extra2);
    exp_q.push_back(((base + 0) << 8) | int'((p3 >> 8) & 255));
    exp_q.push_back(((base + 1) << 8) | int'(p3 & 255));
    exp_q.push_back(((base + 2) << 8) | (int'((p1 >> 16) & 3) | extra2));
    exp_q.push_back(((base + 3) << 8) | int'((p1 >> 8) & 255));
    exp_q.push_back(((base + 4) << 8) | int'(p1 & 255));
    exp_q.push_back(((base + 5) << 8) | int'((((p3 >> 16) & 15) << 4) | ((p2 >> 16) & 15)));
    exp_q.push_back(((base + 6) << 8) | int'((p2 >> 8) & 255));
    exp_q.push_back(((base + 7) << 8) | int'(p2 & 255));
  endfunction

  // R3, R4, R5, R6: expected write stream from the formulas
  function automatic void build_expect(longint m, longint n, longint dn, longint dv, int rd);
    longint t, p1, p2;
    t  = (128 * n) / dn;
    p1 = (128 * m + t - 512) & 64'h3FFFF;
    p2 = (128 * n - dn * t) & 64'hFFFFF;
    push_stage(26, p1, p2, dn, 0);
    push_stage(42, (128 * dv - 512) & 64'h3FFFF, 0, 1, rd << 4);
  endfunction

  always @(negedge clk) begin
    case (rdy_mode)
      0: wr_ready <= 1'b1;
      1: wr_ready <= ~wr_ready;
      default: wr_ready <= ($urandom % 3) != 0;
    endcase
  end

  // cycle-by-cycle comparison and model step, between edges
  always @(negedge clk) begin
    #2;
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n) begin
      check(int'(busy), int'(m_state != 0), "R9 busy");
      check(int'(done), int'(m_done), "R9 done");
      check(int'(wr_valid), int'(m_state == 2), "R7/R8 wr_valid");
      if (m_state == 2 && wr_valid && exp_q.size() > 0) begin
        check(int'(wr_addr), exp_q[0] >> 8, "R2/R6 wr_addr");
        check(int'(wr_data), exp_q[0] & 255, "R2/R3/R4/R5 wr_data");
      end
      m_done = 1'b0;
      case (m_state)
        0: if (start) begin
          build_expect(longint'(mult), longint'(num), longint'(denom), longint'(ms_div), int'(rdiv));
          m_state = 1;
          m_cnt   = 0;
        end
        1: begin
          m_cnt++;
          if (m_cnt == LAT) m_state = 2;
        end
        default: if (wr_ready) begin
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) begin
            m_state = 0;
            m_done  = 1'b1;
          end
        end
      endcase
    end
  end

  task automatic run_job(int m, int n, int dn, int dv, int rd, int md);
    @(negedge clk);
    rdy_mode = md;
    mult = 8'(m); num = 20'(n); denom = 20'(dn); ms_div = 12'(dv); rdiv = 3'(rd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: settings changed after capture must not matter
    mult = ~mult; num = ~num; denom = 20'd7; ms_div = ~ms_div; rdiv = ~rdiv;
    repeat (8) @(negedge clk);
    start = 1'b1;  // R2: ignored while busy
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      #3;
      if (m_state == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    #1;
    check(int'(busy), 0, "R1 busy in reset");
    check(int'(wr_valid), 0, "R1 wr_valid in reset");
    check(int'(done), 0, "R1 done in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(int'(busy), 0, "R1 busy after reset");
    check(int'(wr_valid), 0, "R1 wr_valid after reset");
    run_job(36, 0, 1048575, 36, 0, 0);
    run_job(35, 524287, 1048575, 24, 0, 1);
    run_job(90, 1048574, 1048575, 900, 0, 2);
    run_job(15, 1, 1048575, 4, 5, 2);
    run_job(50, 999, 1000, 126, 7, 1);
    run_job(20, 700000, 300000, 10, 1, 0);
    run_job(255, 1048575, 3, 4095, 3, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule